// File: doc/BRIEF.md
# Dual-Slope Centre-Aligned PWM Generator

This block produces symmetric, centre-aligned pulse-width-modulated outputs from one shared up/down counter. The counter climbs from zero to a ceiling, turns round and descends back to zero, then starts again. Each output channel compares the running count against its own threshold. On the rising slope, crossing the threshold drives the channel low. On the falling slope, crossing it drives the channel high again. The pulse therefore sits centred on the bottom of every period. Moving the threshold widens or narrows the pulse around that centre and does not shift its phase.

The ceiling can be a fixed 8-, 9- or 10-bit maximum, or it can come from a programmable register with a floor of 3. A clock-enable divider sets how often the counter advances. Thresholds are double-buffered, so software may write them at any time and a new value only takes effect at the turnaround point.

All configuration goes in through a single-cycle write port. Two single-clock strobes mark the moments the count reaches the ceiling and reaches zero.

Top module: `pwm_dualslope`

## Requirements
- R1: After reset the counter is zero, counting upward and stopped (divider code 0), every threshold is zero, every channel is non-inverted, every output is 1 and both strobes are 0.
- R2: On each divider tick the count moves one step. On the tick where it reaches the ceiling, the direction becomes downward and `top_flag` is 1 for exactly the following clock. On the tick where it reaches zero, the direction becomes upward and `bot_flag` is 1 for exactly the following clock. Each end value lasts one tick, so a period is 2×ceiling ticks.
- R3: Address 0 is the control word. Its bits 1:0 select the ceiling: 0 gives 0x00FF, 1 gives 0x01FF, 2 gives 0x03FF and 3 uses the programmable ceiling. A new control word governs counting from the clock after it is written.
- R4: Address 1 holds the programmable ceiling. A written value below 3 is stored as 3. The reset value is 0xFFFF.
- R5: With a threshold C where 0 < C < ceiling, a non-inverted channel behaves as follows. After an upward step to count N it shows (N < C). After a downward step to count N it shows (N ≤ C). The output register updates on the same edge as the count.
- R6: Control bit 5 inverts channel 0 and bit 6 inverts channel 1. An inverted channel shows the complement of the R5 and R8 levels.
- R7: Addresses 2 and 3 hold the buffered thresholds for channels 0 and 1. A buffered value becomes active only on the tick where the count reaches the ceiling. A write landing on that same edge waits for the next turnaround.
- R8: An active threshold of 0 holds a non-inverted channel at 1. An active threshold equal to or above the ceiling holds it at 0.
- R9: Control bits 4:2 select the divider. Code 1 advances the counter every clock. Codes 2, 3, 4 and 5 advance it once every 8, 64, 256 and 1024 clocks. Codes 0, 6 and 7 stop it. The divider restarts from zero whenever it is stopped.
- R10: If the count is at or above the ceiling while counting upward (the ceiling was lowered), the next tick steps the count down and turns downward without raising `top_flag`.
- R11: Writes to addresses 4 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one register per asserted clock |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| pwm_out | output | 2 | Channel outputs, bit n is channel n |
| top_flag | output | 1 | One-clock strobe after the count reaches the ceiling |
| bot_flag | output | 1 | One-clock strobe after the count reaches zero |

## Verification
Two events can fall on the same edge. One is the turnaround at the ceiling, which copies each threshold buffer into its active register. The other is a software write to that same buffer. The bench uses the ceiling strobe to time a threshold write so that it lands exactly on the next turnaround edge. The scoreboard then expects the old active value to govern one more full period and the new value to appear only after the following turnaround. A second overlap, a ceiling lowered below a rising count, is provoked mid-slope and judged by the absence of a ceiling strobe at the forced reversal.

// File: rtl/pwm_ds_pkg.sv
`timescale 1ns/1ps
package pwm_ds_pkg;

    // ceiling selection codes
    typedef enum logic [1:0] {
        RES_FIX8  = 2'd0,
        RES_FIX9  = 2'd1,
        RES_FIX10 = 2'd2,
        RES_PROG  = 2'd3
    } res_sel_e;

    // divider selection codes
    typedef enum logic [2:0] {
        PSC_OFF     = 3'd0,
        PSC_DIV1    = 3'd1,
        PSC_DIV8    = 3'd2,
        PSC_DIV64   = 3'd3,
        PSC_DIV256  = 3'd4,
        PSC_DIV1024 = 3'd5,
        PSC_RSV6    = 3'd6,
        PSC_RSV7    = 3'd7
    } psc_sel_e;

    // control word field positions
    localparam int CTRL_RES_LSB = 0;
    localparam int CTRL_PSC_LSB = 2;
    localparam int CTRL_INV_LSB = 5;

    // register addresses
    localparam int REG_CTRL = 0;
    localparam int REG_TOP  = 1;
    localparam int REG_CMP0 = 2;

    localparam int TOP_FLOOR   = 3;
    localparam int PSC_MAX_LOG = 10;
    localparam int PSC_W       = PSC_MAX_LOG;

endpackage

// File: rtl/pwm_ds_prescaler.sv
`timescale 1ns/1ps
module pwm_ds_prescaler
    import pwm_ds_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    output logic       tick
);

    typedef struct packed {
        logic [PSC_W-1:0] cnt;
    } psc_state_t;

    psc_state_t       div_q, div_d;
    logic             run;
    logic [PSC_W-1:0] lim;

    always_comb begin
        run = 1'b1;
        lim = '0;
        case (sel)
            PSC_DIV1:    lim = '0;
            PSC_DIV8:    lim = PSC_W'((1 << 3) - 1);
            PSC_DIV64:   lim = PSC_W'((1 << 6) - 1);
            PSC_DIV256:  lim = PSC_W'((1 << 8) - 1);
            PSC_DIV1024: lim = PSC_W'((1 << PSC_MAX_LOG) - 1);
            default: begin
                run = 1'b0;
                lim = '0;
            end
        endcase
        tick      = run && (div_q.cnt == lim);
        div_d.cnt = (!run || tick) ? '0 : div_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

endmodule

// File: rtl/pwm_ds_regs.sv
`timescale 1ns/1ps
module pwm_ds_regs
    import pwm_ds_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [CNT_W-1:0]              wr_data,
    output logic [2:0]                    psc_sel,
    output logic [NUM_CH-1:0]             inv,
    output logic [CNT_W-1:0]              prog_top,
    output logic [NUM_CH-1:0][CNT_W-1:0]  cmp_buf,
    output logic [CNT_W-1:0]              top_val
);

    localparam logic [CNT_W-1:0] TOP_8  = CNT_W'((1 << 8) - 1);
    localparam logic [CNT_W-1:0] TOP_9  = CNT_W'((1 << 9) - 1);
    localparam logic [CNT_W-1:0] TOP_10 = CNT_W'((1 << 10) - 1);
    localparam logic [CNT_W-1:0] TOP_LO = CNT_W'(TOP_FLOOR);

    typedef struct packed {
        logic [1:0]                   res;
        logic [2:0]                   psc;
        logic [NUM_CH-1:0]            inv;
        logic [CNT_W-1:0]             ptop;
        logic [NUM_CH-1:0][CNT_W-1:0] cmp;
    } reg_state_t;

    reg_state_t rf_q, rf_d;

    always_comb begin
        rf_d = rf_q;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(REG_CTRL)) begin
                rf_d.res = wr_data[CTRL_RES_LSB +: 2];
                rf_d.psc = wr_data[CTRL_PSC_LSB +: 3];
                rf_d.inv = wr_data[CTRL_INV_LSB +: NUM_CH];
            end
            if (wr_addr == ADDR_W'(REG_TOP)) begin
                rf_d.ptop = (wr_data < TOP_LO) ? TOP_LO : wr_data;
            end
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (wr_addr == ADDR_W'(REG_CMP0 + ch)) rf_d.cmp[ch] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q.res  <= RES_FIX8;
            rf_q.psc  <= PSC_OFF;
            rf_q.inv  <= '0;
            rf_q.ptop <= '1;
            rf_q.cmp  <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    always_comb begin
        case (rf_q.res)
            RES_FIX8:  top_val = TOP_8;
            RES_FIX9:  top_val = TOP_9;
            RES_FIX10: top_val = TOP_10;
            default:   top_val = rf_q.ptop;
        endcase
    end

    assign psc_sel  = rf_q.psc;
    assign inv      = rf_q.inv;
    assign prog_top = rf_q.ptop;
    assign cmp_buf  = rf_q.cmp;

endmodule

// File: rtl/pwm_ds_counter.sv
`timescale 1ns/1ps
module pwm_ds_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] top_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             arr_up_nxt,
    output logic             reach_top,
    output logic             top_flag,
    output logic             bot_flag
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dir_up;
        logic             arr_up;
        logic             f_top;
        logic             f_bot;
    } ctr_state_t;

    ctr_state_t ctr_q, ctr_d;

    always_comb begin
        ctr_d       = ctr_q;
        ctr_d.f_top = 1'b0;
        ctr_d.f_bot = 1'b0;
        if (tick) begin
            if (ctr_q.dir_up) begin
                if (ctr_q.cnt >= top_val) begin
                    // ceiling moved below the count: reverse, no strobe
                    ctr_d.cnt    = ctr_q.cnt - 1'b1;
                    ctr_d.dir_up = 1'b0;
                    ctr_d.arr_up = 1'b0;
                end else begin
                    ctr_d.cnt    = ctr_q.cnt + 1'b1;
                    ctr_d.arr_up = 1'b1;
                    if (ctr_q.cnt + 1'b1 == top_val) begin
                        ctr_d.dir_up = 1'b0;
                        ctr_d.f_top  = 1'b1;
                    end
                end
            end else begin
                ctr_d.cnt    = ctr_q.cnt - 1'b1;
                ctr_d.arr_up = 1'b0;
                if (ctr_q.cnt == CNT_W'(1)) begin
                    ctr_d.dir_up = 1'b1;
                    ctr_d.f_bot  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q.cnt    <= '0;
            ctr_q.dir_up <= 1'b1;
            ctr_q.arr_up <= 1'b1;
            ctr_q.f_top  <= 1'b0;
            ctr_q.f_bot  <= 1'b0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign cnt_q      = ctr_q.cnt;
    assign cnt_nxt    = ctr_d.cnt;
    assign arr_up_nxt = ctr_d.arr_up;
    assign reach_top  = ctr_d.f_top;
    assign top_flag   = ctr_q.f_top;
    assign bot_flag   = ctr_q.f_bot;

endmodule

// File: rtl/pwm_ds_channel.sv
`timescale 1ns/1ps
module pwm_ds_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] cmp_buf,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic             arr_up_nxt,
    input  logic [CNT_W-1:0] top_val,
    input  logic             inv,
    output logic [CNT_W-1:0] cmp_act,
    output logic             pwm
);

    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic             lvl;
    } ch_state_t;

    ch_state_t ch_q, ch_d;
    logic      raw;

    always_comb begin
        ch_d.cmp = load ? cmp_buf : ch_q.cmp;
        if (ch_d.cmp == '0)            raw = 1'b1;
        else if (ch_d.cmp >= top_val)  raw = 1'b0;
        else if (arr_up_nxt)           raw = (cnt_nxt < ch_d.cmp);
        else                           raw = (cnt_nxt <= ch_d.cmp);
        ch_d.lvl = raw ^ inv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q.cmp <= '0;
            ch_q.lvl <= 1'b1;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign cmp_act = ch_q.cmp;
    assign pwm     = ch_q.lvl;

endmodule

// File: rtl/pwm_dualslope.sv
`timescale 1ns/1ps
module pwm_dualslope #(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NUM_CH-1:0] pwm_out,
    output logic              top_flag,
    output logic              bot_flag
);

    logic [2:0]                   psc_sel;
    logic [NUM_CH-1:0]            inv;
    logic [CNT_W-1:0]             prog_top;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_buf;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_act;
    logic [CNT_W-1:0]             top_val;
    logic                         tick;
    logic [CNT_W-1:0]             cnt_q;
    logic [CNT_W-1:0]             cnt_nxt;
    logic                         arr_up_nxt;
    logic                         reach_top;

    pwm_ds_regs #(
        .CNT_W (CNT_W),
        .NUM_CH(NUM_CH),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .psc_sel (psc_sel),
        .inv     (inv),
        .prog_top(prog_top),
        .cmp_buf (cmp_buf),
        .top_val (top_val)
    );

    pwm_ds_prescaler u_psc (
        .clk  (clk),
        .rst_n(rst_n),
        .sel  (psc_sel),
        .tick (tick)
    );

    pwm_ds_counter #(
        .CNT_W(CNT_W)
    ) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .top_val   (top_val),
        .cnt_q     (cnt_q),
        .cnt_nxt   (cnt_nxt),
        .arr_up_nxt(arr_up_nxt),
        .reach_top (reach_top),
        .top_flag  (top_flag),
        .bot_flag  (bot_flag)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        pwm_ds_channel #(
            .CNT_W(CNT_W)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (reach_top),
            .cmp_buf   (cmp_buf[ch]),
            .cnt_nxt   (cnt_nxt),
            .arr_up_nxt(arr_up_nxt),
            .top_val   (top_val),
            .inv       (inv[ch]),
            .cmp_act   (cmp_act[ch]),
            .pwm       (pwm_out[ch])
        );
    end

endmodule

// File: rtl/pwm_dualslope_chk.sv
`timescale 1ns/1ps
module pwm_dualslope_chk #(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         top_flag,
    input logic                         bot_flag,
    input logic [CNT_W-1:0]             cnt_q,
    input logic [CNT_W-1:0]             top_val,
    input logic [CNT_W-1:0]             prog_top,
    input logic [2:0]                   psc_sel,
    input logic [NUM_CH-1:0][CNT_W-1:0] cmp_act
);

    // R2
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(top_flag && bot_flag));

    // R2
    top_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        top_flag |=> !top_flag);

    // R2
    top_at_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        top_flag |-> (cnt_q == $past(top_val)));

    // R2
    bot_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bot_flag |-> (cnt_q == '0));

    // R4
    top_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_top >= CNT_W'(3));

    // R9
    halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (psc_sel == 3'd0 || psc_sel > 3'd5) |=> $stable(cnt_q));

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
        // R7
        cmp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(cmp_act[ch]) |-> top_flag);
    end

endmodule

bind pwm_dualslope pwm_dualslope_chk #(
    .CNT_W (CNT_W),
    .NUM_CH(NUM_CH)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .top_flag(top_flag),
    .bot_flag(bot_flag),
    .cnt_q   (cnt_q),
    .top_val (top_val),
    .prog_top(prog_top),
    .psc_sel (psc_sel),
    .cmp_act (cmp_act)
);

// File: tb/pwm_dualslope_test.sv
`timescale 1ns/1ps
module pwm_dualslope_test;

    localparam int CW  = 16;
    localparam int NCH = 2;
    localparam int AW  = 3;

    logic           clk     = 1'b0;
    logic           rst_n   = 1'b0;
    logic           wr_en   = 1'b0;
    logic [AW-1:0]  wr_addr = '0;
    logic [CW-1:0]  wr_data = '0;
    logic [NCH-1:0] pwm_out;
    logic           top_flag;
    logic           bot_flag;

    pwm_dualslope #(.CNT_W(CW), .NUM_CH(NCH), .ADDR_W(AW)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_out (pwm_out),
        .top_flag(top_flag),
        .bot_flag(bot_flag)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic [NCH-1:0] pwm;
        logic           tf;
        logic           bf;
    } exp_t;

    exp_t  sb_q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // reference state, rebuilt from the requirements
    int         m_cnt, m_ptop, m_psc;
    bit         m_up, m_arr;
    logic [1:0] m_res;
    logic [2:0] m_sel;
    logic [NCH-1:0] m_inv;
    int         m_buf [NCH];
    int         m_act [NCH];

    // driver side: advance the reference one clock and queue the expectation
    always @(posedge clk) begin : model
        int   lim, topv;
        bit   run, tk, ft, fb, lvl;
        exp_t e;
        if (!rst_n) begin
            m_cnt = 0; m_up = 1; m_arr = 1; m_psc = 0;
            m_res = 0; m_sel = 0; m_inv = 0; m_ptop = 65535;
            for (int i = 0; i < NCH; i++) begin m_buf[i] = 0; m_act[i] = 0; end
        end else begin
            run = 1;
            case (m_sel)
                3'd1: lim = 0;
                3'd2: lim = 7;
                3'd3: lim = 63;
                3'd4: lim = 255;
                3'd5: lim = 1023;
                default: begin run = 0; lim = 0; end
            endcase
            tk    = run && (m_psc == lim);
            m_psc = (!run || tk) ? 0 : m_psc + 1;
            case (m_res)
                2'd0: topv = 255;
                2'd1: topv = 511;
                2'd2: topv = 1023;
                default: topv = m_ptop;
            endcase
            ft = 0; fb = 0;
            if (tk) begin
                if (m_up) begin
                    if (m_cnt >= topv) begin m_cnt = m_cnt - 1; m_up = 0; m_arr = 0; end
                    else begin
                        m_cnt = m_cnt + 1; m_arr = 1;
                        if (m_cnt == topv) begin m_up = 0; ft = 1; end
                    end
                end else begin
                    m_cnt = m_cnt - 1; m_arr = 0;
                    if (m_cnt == 0) begin m_up = 1; fb = 1; end
                end
            end
            if (ft) for (int i = 0; i < NCH; i++) m_act[i] = m_buf[i];
            for (int i = 0; i < NCH; i++) begin
                if (m_act[i] == 0)         lvl = 1;
                else if (m_act[i] >= topv) lvl = 0;
                else if (m_arr)            lvl = (m_cnt < m_act[i]);
                else                       lvl = (m_cnt <= m_act[i]);
                e.pwm[i] = lvl ^ m_inv[i];
            end
            e.tf = ft;
            e.bf = fb;
            if (wr_en) begin
                case (int'(wr_addr))
                    0: begin m_res = wr_data[1:0]; m_sel = wr_data[4:2]; m_inv = wr_data[6:5]; end
                    1: m_ptop = (int'(wr_data) < 3) ? 3 : int'(wr_data);
                    2: m_buf[0] = int'(wr_data);
                    3: m_buf[1] = int'(wr_data);
                    default: ;
                endcase
            end
            sb_q.push_back(e);
        end
    end

    // monitor side: compare away from the active edge
    always @(negedge clk) begin : monitor
        exp_t e;
        exp_t a;
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            a = {pwm_out, top_flag, bot_flag};
            n_vec++;
            if (a !== e) begin
                n_bad++;
                $display("FAIL %s t=%0t: pwm=%b top=%b bot=%b, expected pwm=%b top=%b bot=%b",
                         cur_req, $time, a.pwm, a.tf, a.bf, e.pwm, e.tf, e.bf);
            end
        end
    end

    task automatic wr(input int a, input int v);
        wr_en   = 1'b1;
        wr_addr = AW'(a);
        wr_data = CW'(v);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired during %s: got running, expected finished", cur_req);
        finish_run();
    end

    initial begin : stim
        // R1: reset state
        repeat (3) @(negedge clk);
        n_vec++;
        if ({pwm_out, top_flag, bot_flag} !== 4'b1100) begin
            n_bad++;
            $display("FAIL R1 reset: got %b, expected 1100", {pwm_out, top_flag, bot_flag});
        end
        rst_n = 1'b1;
        cur_req = "R1 R9 halted";
        run(5);

        // R2 R3 R5 R7: programmable ceiling 6, thresholds 2 and 4, divide by 1
        cur_req = "R2 R3 R5 R7";
        wr(1, 6); wr(2, 2); wr(3, 4); wr(0, 3 | (1 << 2));
        run(60);

        // R7: threshold write landing on the turnaround edge
        cur_req = "R7 write on turnaround";
        while (top_flag !== 1'b1) @(negedge clk);
        run(11);
        wr(2, 5);
        run(40);

        // R6: inversion per channel
        cur_req = "R6";
        wr(0, 3 | (1 << 2) | (1 << 5)); run(40);
        wr(0, 3 | (1 << 2) | (3 << 5)); run(30);
        wr(0, 3 | (1 << 2));            run(10);

        // R8: extreme thresholds
        cur_req = "R8";
        wr(2, 0); wr(3, 6); run(30);
        wr(3, 9); run(30);
        wr(0, 3 | (1 << 2) | (1 << 6)); run(30);
        wr(0, 3 | (1 << 2));

        // R4: ceiling floor
        cur_req = "R4";
        wr(1, 1); run(30);
        wr(1, 0); run(20);
        wr(1, 4); run(20);

        // R10: ceiling lowered under a rising count
        cur_req = "R10";
        wr(2, 7); wr(3, 12); wr(1, 20);
        while (bot_flag !== 1'b1) @(negedge clk);
        run(10);
        wr(1, 5);
        run(40);

        // R11: unmapped addresses
        cur_req = "R11";
        wr(4, 16'hFFFF); wr(5, 0); wr(6, 16'h1234); wr(7, 0);
        run(30);

        // R3: fixed ceilings
        cur_req = "R3 fixed ceilings";
        wr(2, 100); wr(3, 300); wr(0, 0 | (1 << 2)); run(1100);
        wr(0, 1 | (1 << 2)); run(1100);
        wr(2, 700); wr(0, 2 | (1 << 2)); run(2200);

        // R9: divider codes with ceiling 3
        cur_req = "R9";
        wr(1, 3); wr(2, 1); wr(3, 2); wr(0, 3 | (1 << 2)); run(2100);
        wr(0, 3 | (2 << 2)); run(120);
        wr(0, 3 | (3 << 2)); run(900);
        wr(0, 3 | (4 << 2)); run(3300);
        wr(0, 3 | (5 << 2)); run(13000);
        wr(0, 3 | (6 << 2)); run(50);
        wr(0, 3 | (7 << 2)); run(50);
        wr(0, 3);            run(50);

        finish_run();
    end

endmodule